// File: doc/BRIEF.md
# Timer Count-Clock Front End

This block turns one of several clock sources into the count-enable strobe for a single 16-bit timer channel. Everything runs on one fast system clock. Slow internal oscillators reach the block as one-cycle enable pulses. One external event pin can also be used, in its true or its inverted sense. A 3-bit selector picks the source. A free-running prescaler then passes only every 2^N-th event of that source, where N is a 4-bit division setting.

The strobe can be frozen in two situations. Each source has its own sleep-off bit, which freezes the strobe while the system is asleep. A debug-run bit decides whether the strobe keeps running while the processor is halted for debug. While the strobe is frozen, nothing in the block advances.

Pin events pass through a synchronizer and an edge detector. The first two qualifying pin edges after reset, and after any change of source, are thrown away as dummy edges. A small 16-bit up-counter makes the strobe visible and reports each wrap to zero.

Top module: `timer_clk_front`

## Requirements
- R1: After reset `count` is 0, and `countStrobe` and `wrapPulse` are 0. Each cycle with `countStrobe` high adds exactly 1 to `count` at the next clock edge. In every other cycle `count` holds its value.
- R2: For `srcSel` codes 0 to 5, the source is `intEn[srcSel]`. A strobe can only occur in a cycle where that enable bit is high. Pulses on the other enable bits have no effect on the count.
- R3: With `divSel` = d, after the prescaler has been cleared, the strobe comes on the 2^d-th qualifying source event. After that it comes on every 2^d-th event. d = 0 passes every event.
- R4: Code 6 counts rising edges of `extPin`, and code 7 counts falling edges. The strobe is high during the second clock cycle after the pin changes, counted at the sampling edges. It lasts one cycle. Edges of the opposite polarity do nothing.
- R5: With code 6 or 7, the first two qualifying pin edges after reset, or after a change of `srcSel`, do not advance the count. The third edge gives the first increment.
- R6: While `sleepReq` is high and `slpOff[srcSel]` is 1, no strobe occurs, and the count and prescaler hold. With `slpOff[srcSel]` at 0, counting continues during sleep. When sleep ends, counting resumes from the held value.
- R7: While `dbgHalt` is high and `dbgRun` is 0, no strobe occurs, and the count and prescaler hold. With `dbgRun` at 1, counting continues during the halt.
- R8: When `srcSel` differs from its value in the previous cycle, that cycle carries no strobe. The prescaler is cleared and the dummy-edge requirement restarts. The count is left unchanged.
- R9: The count wraps from 0xFFFF to 0x0000. `wrapPulse` is high for exactly the one cycle after the wrapping edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous to `clk` |
| srcSel | input | 3 | Source code: 0-5 internal enables, 6 pin rising edges, 7 pin falling edges |
| divSel | input | 4 | Division exponent, giving a ratio of 2^divSel |
| intEn | input | 6 | One-cycle enable pulses from the internal clock sources |
| extPin | input | 1 | Asynchronous external event pin |
| sleepReq | input | 1 | System sleep state |
| dbgHalt | input | 1 | Processor debug halt state |
| slpOff | input | 8 | Per-source sleep-off bits, indexed by source code |
| dbgRun | input | 1 | 1 keeps counting during a debug halt |
| countStrobe | output | 1 | Count-enable strobe to the timer |
| count | output | 16 | Observation counter value |
| wrapPulse | output | 1 | One-cycle pulse after the counter wraps |

## Verification
A change of `srcSel` and a live event on the newly selected source can land in the same cycle. The bench provokes this by changing the selector and raising the new source's enable bit on the same drive edge. The count must stay put in that cycle. The next events must then show a cleared prescaler: with a ratio of 2, the first event after the change gives no increment and the second one gives an increment. A prescaler that had not been cleared, or an event that had not been dropped, would shift that pattern by one.

// File: rtl/tclk_pkg.sv
package tclk_pkg;
  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic srcPulse;  // one qualified event of the selected source
    logic preClr;    // clear the prescaler
  } tclkStrobe_t;
endpackage

// File: rtl/tclk_ctrl.sv
module tclk_ctrl
  import tclk_pkg::*;
#(
  parameter int SRC_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DUMMY_EDGES = 2,
  localparam int NUM_SRC    = 2 ** SRC_W,
  localparam int NUM_INT    = NUM_SRC - 2,
  localparam int PIN_RISE   = NUM_SRC - 2,
  localparam int PIN_FALL   = NUM_SRC - 1,
  localparam int DUM_W      = $clog2(DUMMY_EDGES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_W-1:0]   srcSel,
  input  logic [NUM_INT-1:0] intEn,
  input  logic               extPin,
  input  logic               sleepReq,
  input  logic               dbgHalt,
  input  logic [NUM_SRC-1:0] slpOff,
  input  logic               dbgRun,
  output tclkStrobe_t        strb
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinPrev;
  logic pinS;
  logic riseEv, fallEv;
  logic [SRC_W-1:0] srcSelQ;
  logic srcChg;
  logic [NUM_SRC-1:0] evVec;
  logic rawEv;
  logic gate;
  logic pinSel;
  logic qualified;
  logic needDummy;
  logic [DUM_W-1:0] dummyCnt;

  // Synchronizer chain for the asynchronous pin.
  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= extPin;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= 1'b0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign pinS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinPrev <= 1'b0;
      srcSelQ <= '0;
    end else begin
      pinPrev <= pinS;
      srcSelQ <= srcSel;
    end
  end

  assign riseEv = pinS & ~pinPrev;
  assign fallEv = ~pinS & pinPrev;
  assign srcChg = (srcSel != srcSelQ);

  // Event vector indexed by source code: internal enables, then pin edges.
  assign evVec  = {fallEv, riseEv, intEn};
  assign rawEv  = evVec[srcSel];
  assign pinSel = (srcSel == SRC_W'(PIN_RISE)) || (srcSel == SRC_W'(PIN_FALL));

  assign gate      = (sleepReq & slpOff[srcSel]) | (dbgHalt & ~dbgRun);
  assign qualified = rawEv & ~gate & ~srcChg;
  assign needDummy = pinSel & (dummyCnt < DUM_W'(DUMMY_EDGES));

  always_ff @(posedge clk) begin
    if (!rstN)                       dummyCnt <= '0;
    else if (srcChg)                 dummyCnt <= '0;
    else if (qualified && needDummy) dummyCnt <= dummyCnt + 1'b1;
  end

  assign strb.srcPulse = qualified & ~needDummy;
  assign strb.preClr   = srcChg;

endmodule

// File: rtl/tclk_dp.sv
module tclk_dp
  import tclk_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DIV_W    = 4,
  localparam int PRE_W   = (2 ** DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  tclkStrobe_t      strb,
  input  logic [DIV_W-1:0] divSel,
  output logic             countStrobe,
  output logic [CNT_W-1:0] count,
  output logic             wrapPulse
);

  logic [PRE_W-1:0] pre;
  logic [PRE_W:0]   maskWide;
  logic [PRE_W-1:0] divMask;
  logic             tick;

  assign maskWide = ({{PRE_W{1'b0}}, 1'b1} << divSel) - 1'b1;
  assign divMask  = maskWide[PRE_W-1:0];
  assign tick     = strb.srcPulse & ((pre & divMask) == divMask);

  always_ff @(posedge clk) begin
    if (!rstN)              pre <= '0;
    else if (strb.preClr)   pre <= '0;
    else if (strb.srcPulse) pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      wrapPulse <= 1'b0;
    end else begin
      wrapPulse <= tick & (&count);
      if (tick) count <= count + 1'b1;
    end
  end

  assign countStrobe = tick;

endmodule

// File: rtl/timer_clk_front.sv
module timer_clk_front
  import tclk_pkg::*;
#(
  parameter int SRC_W       = 3,
  parameter int DIV_W       = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DUMMY_EDGES = 2,
  localparam int NUM_SRC    = 2 ** SRC_W,
  localparam int NUM_INT    = NUM_SRC - 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_W-1:0]   srcSel,
  input  logic [DIV_W-1:0]   divSel,
  input  logic [NUM_INT-1:0] intEn,
  input  logic               extPin,
  input  logic               sleepReq,
  input  logic               dbgHalt,
  input  logic [NUM_SRC-1:0] slpOff,
  input  logic               dbgRun,
  output logic               countStrobe,
  output logic [CNT_W-1:0]   count,
  output logic               wrapPulse
);

  tclkStrobe_t strb;

  tclk_ctrl #(
    .SRC_W(SRC_W), .SYNC_STAGES(SYNC_STAGES), .DUMMY_EDGES(DUMMY_EDGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .intEn(intEn), .extPin(extPin),
    .sleepReq(sleepReq), .dbgHalt(dbgHalt), .slpOff(slpOff), .dbgRun(dbgRun),
    .strb(strb)
  );

  tclk_dp #(
    .CNT_W(CNT_W), .DIV_W(DIV_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .divSel(divSel),
    .countStrobe(countStrobe), .count(count), .wrapPulse(wrapPulse)
  );

endmodule

// File: rtl/tclk_checker.sv
module tclk_checker #(
  parameter int SRC_W  = 3,
  parameter int CNT_W  = 16,
  localparam int NUM_SRC = 2 ** SRC_W,
  localparam int NUM_INT = NUM_SRC - 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [SRC_W-1:0]   srcSel,
  input logic [NUM_INT-1:0] intEn,
  input logic               sleepReq,
  input logic               dbgHalt,
  input logic [NUM_SRC-1:0] slpOff,
  input logic               dbgRun,
  input logic               countStrobe,
  input logic [CNT_W-1:0]   count,
  input logic               wrapPulse
);

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    countStrobe |=> count == $past(count) + 1'b1); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !countStrobe |=> $stable(count)); // R1

  AST_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (countStrobe && (int'(srcSel) < NUM_INT)) |-> ((intEn >> srcSel) & 1'b1) != '0); // R2

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && slpOff[srcSel]) |-> !countStrobe); // R6

  AST_DEBUG_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (dbgHalt && !dbgRun) |=> $stable(count)); // R7

  AST_SRC_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel != $past(srcSel)) |-> !countStrobe); // R8

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> (count == '0 && $past(count) == '1)); // R9

  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> !wrapPulse); // R9

endmodule

bind timer_clk_front tclk_checker #(.SRC_W(SRC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .srcSel(srcSel), .intEn(intEn), .sleepReq(sleepReq),
  .dbgHalt(dbgHalt), .slpOff(slpOff), .dbgRun(dbgRun),
  .countStrobe(countStrobe), .count(count), .wrapPulse(wrapPulse)
);

// File: tb/timer_clk_front_bench.sv
`timescale 1ns/1ps
module timer_clk_front_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  srcSel;
  logic [3:0]  divSel;
  logic [5:0]  intEn;
  logic        extPin;
  logic        sleepReq;
  logic        dbgHalt;
  logic [7:0]  slpOff;
  logic        dbgRun;
  logic        countStrobe;
  logic [15:0] count;
  logic        wrapPulse;

  int checks = 0;
  int errors = 0;
  int expCount = 0;

  always #4 clk = ~clk;  // 125 MHz

  timer_clk_front u_timer_clk_front (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .divSel(divSel), .intEn(intEn),
    .extPin(extPin), .sleepReq(sleepReq), .dbgHalt(dbgHalt), .slpOff(slpOff),
    .dbgRun(dbgRun), .countStrobe(countStrobe), .count(count),
    .wrapPulse(wrapPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic setSrc(input logic [2:0] s);
    step(); srcSel = s;
    step();
  endtask

  task automatic pulseInt(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      step(); intEn = 6'(1 << idx);
      step(); intEn = '0;
    end
    step();
  endtask

  task automatic holdInt(input int idx, input int n);
    step(); intEn = 6'(1 << idx);
    repeat (n) step();
    intEn = '0;
    step();
  endtask

  task automatic pinTo(input logic v);
    step(); extPin = v;
    repeat (4) step();
  endtask

  task automatic t_reset();
    chk("R1 count after reset", count, 0);
    chk("R1 strobe after reset", countStrobe, 0);
    chk("R9 wrap after reset", wrapPulse, 0);
  endtask

  task automatic t_internal();
    setSrc(3'd2);
    pulseInt(2, 5); expCount += 5;
    chk("R2 selected source counts", count, expCount);
    pulseInt(4, 3);
    chk("R2 other source ignored", count, expCount);
  endtask

  task automatic t_divide();
    divSel = 4'd2;
    setSrc(3'd1);
    pulseInt(1, 3);
    chk("R3 div4 no strobe before fourth", count, expCount);
    pulseInt(1, 1); expCount += 1;
    chk("R3 div4 fourth event", count, expCount);
    pulseInt(1, 8); expCount += 2;
    chk("R3 div4 steady ratio", count, expCount);
    divSel = 4'd0;
  endtask

  task automatic t_pinRise();
    setSrc(3'd6);
    pinTo(1'b1); pinTo(1'b0);
    pinTo(1'b1); pinTo(1'b0);
    chk("R5 two dummy rising edges", count, expCount);
    step(); extPin = 1'b1;
    step(); chk("R4 strobe not yet", countStrobe, 0);
    step(); chk("R4 strobe on second cycle", countStrobe, 1);
    step(); chk("R4 strobe one cycle", countStrobe, 0);
    expCount += 1;
    chk("R4 third rising edge counts", count, expCount);
    pinTo(1'b0);
    chk("R4 falling edge ignored in rise mode", count, expCount);
    pinTo(1'b1); expCount += 1;
    chk("R4 next rising edge counts", count, expCount);
    pinTo(1'b0);
  endtask

  task automatic t_pinFall();
    setSrc(3'd7);
    pinTo(1'b1); pinTo(1'b0);
    pinTo(1'b1); pinTo(1'b0);
    chk("R5 dummy edges restart after change", count, expCount);
    pinTo(1'b1);
    chk("R4 rising edge ignored in fall mode", count, expCount);
    pinTo(1'b0); expCount += 1;
    chk("R4 falling edge counts", count, expCount);
  endtask

  task automatic t_sleep();
    setSrc(3'd1);
    slpOff = 8'h02; sleepReq = 1'b1;
    pulseInt(1, 4);
    chk("R6 sleep freezes count", count, expCount);
    slpOff = 8'hFD;
    pulseInt(1, 2); expCount += 2;
    chk("R6 sleep-off clear keeps counting", count, expCount);
    slpOff = 8'h02; sleepReq = 1'b0;
    pulseInt(1, 1); expCount += 1;
    chk("R6 resume after sleep", count, expCount);
    slpOff = '0;
  endtask

  task automatic t_debug();
    dbgRun = 1'b0; dbgHalt = 1'b1;
    pulseInt(1, 3);
    chk("R7 halt freezes count", count, expCount);
    dbgRun = 1'b1;
    pulseInt(1, 2); expCount += 2;
    chk("R7 debug-run counts in halt", count, expCount);
    dbgHalt = 1'b0; dbgRun = 1'b0;
    pulseInt(1, 1); expCount += 1;
    chk("R7 resume after halt", count, expCount);
  endtask

  task automatic t_srcChange();
    divSel = 4'd1;
    setSrc(3'd4);
    pulseInt(4, 1);
    chk("R8 div2 first event no strobe", count, expCount);
    step(); srcSel = 3'd2; intEn = 6'b000100;
    step(); intEn = '0;
    step();
    chk("R8 change cycle drops event", count, expCount);
    pulseInt(2, 1);
    chk("R8 prescaler cleared by change", count, expCount);
    pulseInt(2, 1); expCount += 1;
    chk("R8 second event after change", count, expCount);
    divSel = 4'd0;
  endtask

  task automatic t_wrap();
    setSrc(3'd3);
    holdInt(3, 65535 - expCount);
    expCount = 65535;
    chk("R9 count at max", count, expCount);
    chk("R9 no wrap pulse yet", wrapPulse, 0);
    step(); intEn = 6'b001000;
    step(); intEn = '0;
    chk("R9 wraps to zero", count, 0);
    chk("R9 wrap pulse", wrapPulse, 1);
    step();
    chk("R9 wrap pulse one cycle", wrapPulse, 0);
  endtask

  initial begin
    rstN = 1'b0; srcSel = '0; divSel = '0; intEn = '0; extPin = 1'b0;
    sleepReq = 1'b0; dbgHalt = 1'b0; slpOff = '0; dbgRun = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    step();
    t_reset();
    t_internal();
    t_divide();
    t_pinRise();
    t_pinFall();
    t_sleep();
    t_debug();
    t_srcChange();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule